// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. It keeps a small on-chip segment table. Each entry holds a base address, a length (limit), an enable bit and three access-right bits: read, write and execute. A separate length register sets how many segment numbers are legal. A requester presents a segment number, an offset and an access kind for one cycle. One cycle later the block returns either the physical address or a fault with a cause code.

Software loads table entries and the length register through a single-cycle configuration write port. A write that lands in the same cycle as a request changes only the requests that come after it. The request in that cycle is judged against the table as it stood before the write.

Control is a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is presented this cycle. The transition `T_ACCEPT` is taken from either state when `req_valid` is high and enters `ST_RESULT`. The transition `T_DRAIN` is taken from either state when `req_valid` is low and enters `ST_IDLE`. Because of this, back-to-back requests give back-to-back results.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` is low, the length register holds 0 and every entry is disabled, so the first request returns a range fault.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` was high, and low otherwise. When `rsp_valid` is low, `rsp_fault` is low.
- R3: A request whose segment number is greater than or equal to the length register faults with cause 2'b00.
- R4: A request that passes R3 but selects an entry whose enable bit is clear faults with cause 2'b01.
- R5: A request that passes R3 and R4 but whose offset is greater than or equal to the entry limit faults with cause 2'b10. A limit of 0 makes every offset fault.
- R6: A request that passes R3 to R5 but whose access kind is not granted faults with cause 2'b11. Access kind 2'b00 is read and needs `cfg_perm` bit 0. Kind 2'b01 is write and needs bit 1. Kind 2'b10 is execute and needs bit 2. Kind 2'b11 is never granted.
- R7: When several checks fail at once, the reported cause is the first failing one in the order range, enable, limit, access.
- R8: A request that passes all checks returns `rsp_fault` low, cause 2'b00, and `rsp_paddr` equal to base plus offset, modulo 2^PA_W.
- R9: A configuration write in the same cycle as a request does not affect that request's result. It does affect the next request.
- R10: On a fault, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len_sel | input | 1 | 1 writes the length register, 0 writes entry `cfg_idx` |
| cfg_idx | input | SEG_W | Entry index to write |
| cfg_base | input | PA_W | Entry base address |
| cfg_limit | input | OFF_W+1 | Entry limit, in addressable units |
| cfg_ok | input | 1 | Entry enable bit |
| cfg_perm | input | 3 | Access rights: bit0 read, bit1 write, bit2 execute |
| cfg_len | input | SEG_W+1 | New length register value |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | 2 | Fault cause: 0 range, 1 disabled, 2 limit, 3 access |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |

## Verification
A table update and a translation can fall in the same cycle. In that case the result must come from the table as it stood before the edge. The bench provokes this in two ways. It disables an entry in the same cycle that a request reads it. It also raises the length register in the same cycle that a request uses the segment it newly admits. Each time, the bench checks that the result in that cycle matches the old table, and that the result of the following request matches the new one. A random phase then mixes requests with writes in about a fifth of its cycles. The bench's reference model scores those cycles the same way.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SX_SEG_W = 3;
    localparam int SX_OFF_W = 10;
    localparam int SX_PA_W  = 16;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_RANGE   = 2'b00,
        CAUSE_DISABLE = 2'b01,
        CAUSE_LIMIT   = 2'b10,
        CAUSE_ACCESS  = 2'b11
    } fault_cause_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } xl_state_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_N = 3;

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = SX_SEG_W,
    parameter int OFF_W = SX_OFF_W,
    parameter int PA_W  = SX_PA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_len_sel,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [OFF_W:0]    wr_limit,
    input  logic              wr_ok,
    input  logic [PERM_N-1:0] wr_perm,
    input  logic [SEG_W:0]    wr_len,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [PA_W-1:0]   rd_base,
    output logic [OFF_W:0]    rd_limit,
    output logic              rd_ok,
    output logic [PERM_N-1:0] rd_perm,
    output logic [SEG_W:0]    len_q
);
    localparam int NUM_SEG = 1 << SEG_W;

    logic [PA_W-1:0]   base_q  [NUM_SEG];
    logic [OFF_W:0]    limit_q [NUM_SEG];
    logic              ok_q    [NUM_SEG];
    logic [PERM_N-1:0] perm_q  [NUM_SEG];

    // length register: reset to zero, so no segment is legal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_en && wr_len_sel) begin
            len_q <= wr_len;
        end
    end

    // one register set per entry
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && !wr_len_sel && (wr_idx == SEG_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                ok_q[g]    <= 1'b0;
                perm_q[g]  <= '0;
            end else if (hit) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                ok_q[g]    <= wr_ok;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    // read port sees the pre-edge contents
    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = limit_q[rd_idx];
        rd_ok    = ok_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
    end

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = SX_SEG_W,
    parameter int OFF_W = SX_OFF_W,
    parameter int PA_W  = SX_PA_W
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic [SEG_W:0]    len,
    input  logic [PA_W-1:0]   base,
    input  logic [OFF_W:0]    limit,
    input  logic              ok,
    input  logic [PERM_N-1:0] perm,
    output logic              fault,
    output fault_cause_e      cause,
    output logic [PA_W-1:0]   paddr
);
    logic range_bad;
    logic dis_bad;
    logic lim_bad;
    logic acc_bad;

    always_comb begin
        range_bad = {1'b0, seg} >= len;
        dis_bad   = !ok;
        lim_bad   = {1'b0, off} >= limit;
        unique case (acc_kind_e'(acc))
            ACC_READ:  acc_bad = !perm[PERM_R];
            ACC_WRITE: acc_bad = !perm[PERM_W];
            ACC_EXEC:  acc_bad = !perm[PERM_X];
            ACC_RSVD:  acc_bad = 1'b1;
            default:   acc_bad = 1'b1;
        endcase
    end

    // priority: range, enable, limit, access
    always_comb begin
        fault = 1'b1;
        cause = CAUSE_RANGE;
        paddr = '0;
        if (range_bad) begin
            cause = CAUSE_RANGE;
        end else if (dis_bad) begin
            cause = CAUSE_DISABLE;
        end else if (lim_bad) begin
            cause = CAUSE_LIMIT;
        end else if (acc_bad) begin
            cause = CAUSE_ACCESS;
        end else begin
            fault = 1'b0;
            paddr = base + PA_W'(off);
        end
    end

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int PA_W = SX_PA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            chk_fault,
    input  fault_cause_e    chk_cause,
    input  logic [PA_W-1:0] chk_paddr,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [1:0]      rsp_cause,
    output logic [PA_W-1:0] rsp_paddr
);
    xl_state_e state_q;
    xl_state_e state_d;

    logic            fault_q;
    fault_cause_e    cause_q;
    logic [PA_W-1:0] paddr_q;

    // T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result capture on accept, cleared on drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_RANGE;
            paddr_q <= '0;
        end else if (req_valid) begin
            fault_q <= chk_fault;
            cause_q <= chk_cause;
            paddr_q <= chk_paddr;
        end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_RANGE;
            paddr_q <= '0;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESULT);
        rsp_fault = fault_q;
        rsp_cause = cause_q;
        rsp_paddr = paddr_q;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = SX_SEG_W,
    parameter int OFF_W = SX_OFF_W,
    parameter int PA_W  = SX_PA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    input  logic             cfg_we,
    input  logic             cfg_len_sel,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W:0]   cfg_limit,
    input  logic             cfg_ok,
    input  logic [2:0]       cfg_perm,
    input  logic [SEG_W:0]   cfg_len,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause,
    output logic [PA_W-1:0]  rsp_paddr
);
    logic [PA_W-1:0]   ent_base;
    logic [OFF_W:0]    ent_limit;
    logic              ent_ok;
    logic [PERM_N-1:0] ent_perm;
    logic [SEG_W:0]    tbl_len;

    logic              chk_fault;
    fault_cause_e      chk_cause;
    logic [PA_W-1:0]   chk_paddr;

    seg_xlate_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_len_sel (cfg_len_sel),
        .wr_idx     (cfg_idx),
        .wr_base    (cfg_base),
        .wr_limit   (cfg_limit),
        .wr_ok      (cfg_ok),
        .wr_perm    (cfg_perm),
        .wr_len     (cfg_len),
        .rd_idx     (req_seg),
        .rd_base    (ent_base),
        .rd_limit   (ent_limit),
        .rd_ok      (ent_ok),
        .rd_perm    (ent_perm),
        .len_q      (tbl_len)
    );

    seg_xlate_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .seg   (req_seg),
        .off   (req_off),
        .acc   (req_acc),
        .len   (tbl_len),
        .base  (ent_base),
        .limit (ent_limit),
        .ok    (ent_ok),
        .perm  (ent_perm),
        .fault (chk_fault),
        .cause (chk_cause),
        .paddr (chk_paddr)
    );

    seg_xlate_ctrl #(.PA_W(PA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .chk_fault (chk_fault),
        .chk_cause (chk_cause),
        .chk_paddr (chk_paddr),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   tbl_len,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause,
    input logic [PA_W-1:0]  rsp_paddr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_QUIET_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_fault); // R2

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R10

    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= tbl_len)) |=> (rsp_fault && rsp_cause == 2'b00)); // R3

endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .tbl_len   (tbl_len),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;
    localparam int SEG_W = 3;
    localparam int OFF_W = 10;
    localparam int PA_W  = 16;
    localparam int NSEG  = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             cfg_we = 1'b0;
    logic             cfg_len_sel = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W:0]   cfg_limit = '0;
    logic             cfg_ok = 1'b0;
    logic [2:0]       cfg_perm = '0;
    logic [SEG_W:0]   cfg_len = '0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [1:0]       rsp_cause;
    logic [PA_W-1:0]  rsp_paddr;

    always #2.5 clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .cfg_we(cfg_we),
        .cfg_len_sel(cfg_len_sel), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_ok(cfg_ok), .cfg_perm(cfg_perm),
        .cfg_len(cfg_len), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string force_tag = "";

    // reference model state
    int m_base [NSEG];
    int m_lim  [NSEG];
    int m_ok   [NSEG];
    int m_perm [NSEG];
    int m_len;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: predict from current inputs and old model, then update model
    task automatic step();
        int ev, ef, ec, ea, nfail;
        string tag;
        ev = req_valid; ef = 0; ec = 0; ea = 0; nfail = 0; tag = "R8";
        if (req_valid) begin
            int s, o, a, rb, db, lb, ab;
            s = int'(req_seg); o = int'(req_off); a = int'(req_acc);
            rb = (s >= m_len);
            db = (m_ok[s] == 0);
            lb = (o >= m_lim[s]);
            ab = (a == 3) || ((m_perm[s] >> a) & 1) == 0;
            nfail = rb + db + lb + ab;
            if (rb)      begin ef = 1; ec = 0; tag = "R3"; end
            else if (db) begin ef = 1; ec = 1; tag = "R4"; end
            else if (lb) begin ef = 1; ec = 2; tag = "R5"; end
            else if (ab) begin ef = 1; ec = 3; tag = "R6"; end
            else ea = (m_base[s] + o) & ((1 << PA_W) - 1);
            if (nfail > 1) tag = "R7";
            if (force_tag != "") tag = force_tag;
        end
        if (cfg_we) begin
            if (cfg_len_sel) m_len = int'(cfg_len);
            else begin
                m_base[cfg_idx] = int'(cfg_base);
                m_lim[cfg_idx]  = int'(cfg_limit);
                m_ok[cfg_idx]   = int'(cfg_ok);
                m_perm[cfg_idx] = int'(cfg_perm);
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        force_tag = "";
        chk("R2", int'(rsp_valid), ev);
        if (ev != 0) begin
            chk(tag, int'(rsp_fault), ef);
            chk(tag, int'(rsp_cause), ec);
            chk(ef != 0 ? "R10" : tag, int'(rsp_paddr), ea);
        end else begin
            chk("R2", int'(rsp_fault), 0);
        end
    endtask

    task automatic set_req(input int s, input int o, input int a);
        req_valid = 1'b1;
        req_seg = SEG_W'(s);
        req_off = OFF_W'(o);
        req_acc = 2'(a);
    endtask

    task automatic set_ent(input int i, input int b, input int l, input int ok, input int p);
        cfg_we = 1'b1; cfg_len_sel = 1'b0;
        cfg_idx = SEG_W'(i); cfg_base = PA_W'(b);
        cfg_limit = (OFF_W+1)'(l); cfg_ok = ok[0]; cfg_perm = 3'(p);
    endtask

    task automatic set_len(input int n);
        cfg_we = 1'b1; cfg_len_sel = 1'b1; cfg_len = (SEG_W+1)'(n);
    endtask

    task automatic do_req(input int s, input int o, input int a);
        set_req(s, o, a);
        step();
    endtask

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_ok[i] = 0; m_perm[i] = 0;
        end
        m_len = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(rsp_valid), 0);
        rst_n = 1'b1;
        step();
        // first request after reset: range fault (R1)
        force_tag = "R1";
        do_req(0, 0, 0);

        set_len(4); step();
        set_ent(0, 'h1000, 256, 1, 3); step();
        set_ent(1, 'hFF00, 1024, 1, 4); step();
        set_ent(2, 'h3000, 0, 0, 0); step();
        set_ent(3, 'h2000, 0, 1, 7); step();
        set_ent(5, 'h5000, 100, 1, 7); step();

        // back-to-back requests, R2 and main function R8
        do_req(0, 10, 0);
        do_req(0, 20, 1);
        do_req(0, 255, 0);
        do_req(1, 'h200, 2);    // R8 wrap of base plus offset
        step();
        do_req(0, 30, 2);       // R6 execute not granted
        do_req(1, 5, 0);        // R6 read not granted
        do_req(0, 5, 3);        // R6 reserved kind
        do_req(0, 256, 0);      // R5 offset equal to limit
        do_req(3, 0, 0);        // R5 zero limit
        do_req(2, 0, 0);        // R4 + limit + access -> R7
        do_req(5, 0, 0);        // R3 entry valid but beyond length
        do_req(4, 0, 0);        // R3 boundary
        do_req(3, 5, 3);        // R7 limit before access
        do_req(7, 900, 3);      // R7 range before all

        // R9: disable entry 0 in the request's own cycle
        set_req(0, 40, 0); set_ent(0, 'h1000, 256, 0, 3); force_tag = "R9"; step();
        force_tag = "R9"; do_req(0, 40, 0);
        // R9: raise length in the request's own cycle
        set_req(4, 0, 0); set_len(5); force_tag = "R9"; step();
        force_tag = "R9"; do_req(4, 0, 0);
        set_ent(0, 'h1000, 256, 1, 3); step();

        // random mix of requests and writes
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 4) != 0)
                set_req(int'($urandom % NSEG), int'($urandom % 1024), int'($urandom % 4));
            if (($urandom % 5) == 0) begin
                if (($urandom % 6) == 0) set_len(int'($urandom % (NSEG + 1)));
                else set_ent(int'($urandom % NSEG), int'($urandom % 65536),
                             int'($urandom % 1025), int'($urandom % 4 != 0),
                             int'($urandom % 8));
            end
            step();
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule